// File: doc/BRIEF.md
# Cyclic Ring-Buffer DMA Channel

This block is a single channel of an audio-style DMA engine that runs only in continuous ring-buffer mode. Software programs a memory base address, a period length in bytes, the number of equal periods in the ring (one to eight), a burst code and a peripheral request line. It then sets the global enable and the channel run bit. The channel streams 32-bit words between memory and a peripheral in either direction, forever. At every period boundary it raises an interrupt flag and advances a 16-bit period counter. After the last period it returns to the base address with no idle cycle.

The memory side is a simple word master: a request with address, write enable and write data, completed by a ready strobe, with read data sampled on that same strobe. The peripheral side has one request line per requester, a transmit data strobe toward the peripheral, and an acknowledge that pops received data. Clearing the run bit stops the channel once any memory beat in flight has completed.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset, the active bit (bit 0 at offset 0x0C), the irq output, the period counter (offset 0x54) and memReq all read 0.
- R2: Writing 1 to bit 0 at global offset 0xC04 returns the channel to idle and clears every register, including the global enable. The soft reset bit reads 0 again one cycle after the write.
- R3: The channel starts only while bit 0 of the global command at 0xC00 is 1. With it at 0, setting the run bit (bit 0 at 0x00) issues no memory request and leaves the active bit at 0.
- R4: With direction code 4 in control bits [15:12], the channel reads memory from the source base at 0x34. Each returned word is passed to periphTxData together with a periphTxValid pulse, and memWe stays 0.
- R5: With direction code 2, the channel writes periphRxData to memory from the target base at 0x3C, with memWe at 1 and a periphRxAck pulse on every accepted beat.
- R6: Addresses are word aligned and step by 4. The period length is the transfer count at 0x44 masked to bits [29:2]. The ring holds field+1 periods, the field being config bits [30:28] for direction 4 and [26:24] for direction 2. After the last period the address returns to the base.
- R7: Config bits [22:20] set the burst length: codes 1 to 5 give 1, 2, 4, 8 and 16 words, and any other code gives 16. With flow control (control bit 1) set, a burst starts only while the selected request line is high. That line is control [31:28] for direction 4 and [27:24] for direction 2, and only lines 1 to 10 are valid. A burst is cut short at a period end.
- R8: The irq flag (bit 0 at 0x10, also on the irq pin) sets on the last beat of each period and clears on a write of bit 0 to 0x1C. A period end in the same cycle as a clear leaves the flag set.
- R9: The period counter at 0x54 restarts at 0 when the channel starts, adds one per completed period, and wraps from 0xFFFF to 0.
- R10: Writing 0 to the run bit lets a beat in flight complete, after which no further request is issued and the active bit drops. The irq flag keeps its value.
- R11: Once raised, memReq and memAddr hold steady until memReady is seen.
- R12: The channel starts only with direction code 2 or 4 and mode bits [9:8] equal to 2. Otherwise it stays idle with the active bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 for a memory write beat |
| memAddr | output | 32 | Memory word address |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid with memReady |
| memReady | input | 1 | Completes the current beat |
| periphReq | input | 16 | Peripheral request lines |
| periphTxData | output | 32 | Word sent to the peripheral |
| periphTxValid | output | 1 | periphTxData is valid this cycle |
| periphRxData | input | 32 | Word received from the peripheral |
| periphRxAck | output | 1 | periphRxData consumed this cycle |
| irq | output | 1 | Period-done interrupt flag |

## Verification
The interrupt flag can be set by a period end and cleared by software in the same cycle. The bench provokes this with one-word periods, one-word bursts and an always-ready memory, so that a period ends on every cycle of the run. A clear written then must always collide with a set, and the flag is judged to still read 1 in the cycle that follows. Separately, a clear issued while the channel is idle must drop the flag to 0.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef struct packed {
    logic clear;       // soft reset of datapath state
    logic start;       // load base, period length, zero counter
    logic burstStart;  // load burst length
    logic beat;        // a memory beat completed this cycle
  } dmaStrobe_t;

  localparam logic [3:0] DIR_TO_MEM   = 4'd2;
  localparam logic [3:0] DIR_FROM_MEM = 4'd4;
  localparam logic [1:0] MODE_RING    = 2'd2;

  localparam logic [6:0] OFF_CMD   = 7'h00;
  localparam logic [6:0] OFF_STAT  = 7'h0C;
  localparam logic [6:0] OFF_ISTAT = 7'h10;
  localparam logic [6:0] OFF_ICLR  = 7'h1C;
  localparam logic [6:0] OFF_CTRL  = 7'h24;
  localparam logic [6:0] OFF_CFG   = 7'h28;
  localparam logic [6:0] OFF_SRC   = 7'h34;
  localparam logic [6:0] OFF_TRG   = 7'h3C;
  localparam logic [6:0] OFF_TC    = 7'h44;
  localparam logic [6:0] OFF_XSTAT = 7'h54;

  localparam logic [11:0] GLB_CMD = 12'hC00;
  localparam logic [11:0] GLB_RST = 12'hC04;
endpackage

// File: rtl/ring_dma_ctrl.sv
module ring_dma_ctrl
  import ring_dma_pkg::*;
#(
  parameter int CH_INDEX   = 0,
  parameter int REQ_LINES  = 16,
  parameter int MAX_REQ_ID = 10,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [11:0]          regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 memReady,
  input  logic [REQ_LINES-1:0] periphReq,
  input  logic                 periodEnd,
  input  logic                 burstLast,
  input  logic [CNT_W-1:0]     xferCount,
  output dmaStrobe_t           strobe,
  output logic                 memReq,
  output logic                 isTx,
  output logic [31:0]          baseAddr,
  output logic [2:0]           lastBuf,
  output logic [27:0]          tcWords,
  output logic [4:0]           burstWords,
  output logic                 irq,
  output logic                 runBit,
  output logic                 softRst
);
  localparam int SEL_W = $clog2(REQ_LINES);
  localparam logic [4:0] CH_SEL = CH_INDEX[4:0];

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_XFER} chState_t;
  chState_t state, nextState;

  logic gEn, intFlag;
  logic [31:0] ctrlReg, cfgReg, tcReg, srcReg, trgReg;

  wire chanHit = (regAddr[11:7] == CH_SEL);
  wire wrCh    = regWrEn && chanHit;

  // request lines: line 0 and lines above the limit never grant
  logic [REQ_LINES-1:0] reqOk;
  for (genvar i = 0; i < REQ_LINES; i++) begin : g_req
    assign reqOk[i] = periphReq[i] && (i != 0) && (i <= MAX_REQ_ID);
  end

  wire [3:0] dirCode = ctrlReg[15:12];
  assign isTx = (dirCode == DIR_FROM_MEM);
  wire modeOk = ((dirCode == DIR_FROM_MEM) || (dirCode == DIR_TO_MEM))
                && (ctrlReg[9:8] == MODE_RING);
  wire flowEn = ctrlReg[1];
  wire [SEL_W-1:0] reqSel = isTx ? ctrlReg[28 +: SEL_W] : ctrlReg[24 +: SEL_W];
  wire goOk = !flowEn || reqOk[reqSel];
  wire keepRun = runBit && gEn;

  assign baseAddr = isTx ? srcReg : trgReg;
  assign lastBuf  = isTx ? cfgReg[30:28] : cfgReg[26:24];
  assign tcWords  = tcReg[29:2];
  assign irq      = intFlag;

  always_comb begin
    case (cfgReg[22:20])
      3'd1:    burstWords = 5'd1;
      3'd2:    burstWords = 5'd2;
      3'd3:    burstWords = 5'd4;
      3'd4:    burstWords = 5'd8;
      default: burstWords = 5'd16;
    endcase
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit <= 1'b0; gEn <= 1'b0; softRst <= 1'b0; intFlag <= 1'b0;
      ctrlReg <= '0; cfgReg <= '0; tcReg <= '0; srcReg <= '0; trgReg <= '0;
    end else if (softRst) begin
      runBit <= 1'b0; gEn <= 1'b0; softRst <= 1'b0; intFlag <= 1'b0;
      ctrlReg <= '0; cfgReg <= '0; tcReg <= '0; srcReg <= '0; trgReg <= '0;
    end else begin
      if (regWrEn && regAddr == GLB_CMD) gEn <= regWrData[0];
      if (regWrEn && regAddr == GLB_RST) softRst <= regWrData[0];
      if (wrCh && regAddr[6:0] == OFF_CMD)  runBit  <= regWrData[0];
      if (wrCh && regAddr[6:0] == OFF_CTRL) ctrlReg <= regWrData;
      if (wrCh && regAddr[6:0] == OFF_CFG)  cfgReg  <= regWrData;
      if (wrCh && regAddr[6:0] == OFF_TC)   tcReg   <= regWrData & 32'h3FFF_FFFC;
      if (wrCh && regAddr[6:0] == OFF_SRC)  srcReg  <= {regWrData[31:2], 2'b00};
      if (wrCh && regAddr[6:0] == OFF_TRG)  trgReg  <= {regWrData[31:2], 2'b00};
      // a period end wins over a clear in the same cycle
      if (periodEnd) intFlag <= 1'b1;
      else if (wrCh && regAddr[6:0] == OFF_ICLR && regWrData[0]) intFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == GLB_CMD)      regRdData = {31'd0, gEn};
    else if (regAddr == GLB_RST) regRdData = {31'd0, softRst};
    else if (chanHit) begin
      case (regAddr[6:0])
        OFF_CMD:   regRdData = {31'd0, runBit};
        OFF_STAT:  regRdData = {31'd0, state != S_IDLE};
        OFF_ISTAT: regRdData = {31'd0, intFlag};
        OFF_CTRL:  regRdData = ctrlReg;
        OFF_CFG:   regRdData = cfgReg;
        OFF_SRC:   regRdData = srcReg;
        OFF_TRG:   regRdData = trgReg;
        OFF_TC:    regRdData = tcReg;
        OFF_XSTAT: regRdData = {{(32-CNT_W){1'b0}}, xferCount};
        default:   regRdData = '0;
      endcase
    end
  end

  // channel sequencer
  always_comb begin
    nextState = state;
    strobe = '0;
    strobe.clear = softRst;
    memReq = (state == S_XFER);
    case (state)
      S_IDLE: if (keepRun && modeOk) begin
        strobe.start = 1'b1;
        nextState = S_ARM;
      end
      S_ARM: begin
        if (!keepRun) nextState = S_IDLE;
        else if (goOk) begin
          strobe.burstStart = 1'b1;
          nextState = S_XFER;
        end
      end
      S_XFER: if (memReady) begin
        strobe.beat = 1'b1;
        if (!keepRun) nextState = S_IDLE;
        else if (burstLast) begin
          if (goOk) strobe.burstStart = 1'b1;
          else nextState = S_ARM;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= S_IDLE;
    else if (softRst) state <= S_IDLE;
    else              state <= nextState;
  end
endmodule

// File: rtl/ring_dma_datapath.sv
module ring_dma_datapath
  import ring_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmaStrobe_t       strobe,
  input  logic             isTx,
  input  logic [31:0]      baseAddr,
  input  logic [2:0]       lastBuf,
  input  logic [27:0]      tcWords,
  input  logic [4:0]       burstWords,
  input  logic [31:0]      memRData,
  input  logic [31:0]      periphRxData,
  output logic [31:0]      memAddr,
  output logic             memWe,
  output logic [31:0]      memWData,
  output logic [31:0]      periphTxData,
  output logic             periphTxValid,
  output logic             periphRxAck,
  output logic             periodEnd,
  output logic             burstLast,
  output logic [CNT_W-1:0] xferCount
);
  logic [31:0] curAddr;
  logic [27:0] periodLeft, nextLeft;
  logic [4:0]  burstLeft;
  logic [2:0]  bufIdx;

  assign periodEnd = strobe.beat && (periodLeft == 28'd1);
  assign burstLast = (burstLeft == 5'd1);
  assign nextLeft  = !strobe.beat ? periodLeft
                   : (periodLeft == 28'd1) ? tcWords : periodLeft - 28'd1;

  assign memAddr       = curAddr;
  assign memWe         = !isTx;
  assign memWData      = periphRxData;
  assign periphTxData  = memRData;
  assign periphTxValid = strobe.beat && isTx;
  assign periphRxAck   = strobe.beat && !isTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0; periodLeft <= '0; burstLeft <= '0; bufIdx <= '0; xferCount <= '0;
    end else if (strobe.clear) begin
      curAddr <= '0; periodLeft <= '0; burstLeft <= '0; bufIdx <= '0; xferCount <= '0;
    end else if (strobe.start) begin
      curAddr    <= baseAddr;
      periodLeft <= tcWords;
      bufIdx     <= '0;
      xferCount  <= '0;
    end else begin
      if (strobe.burstStart)
        burstLeft <= ({23'd0, burstWords} > nextLeft) ? nextLeft[4:0] : burstWords;
      else if (strobe.beat)
        burstLeft <= burstLeft - 5'd1;
      if (strobe.beat) begin
        periodLeft <= nextLeft;
        if (periodLeft == 28'd1) begin
          xferCount <= xferCount + 1'b1;
          if (bufIdx == lastBuf) begin
            bufIdx  <= '0;
            curAddr <= baseAddr;
          end else begin
            bufIdx  <= bufIdx + 3'd1;
            curAddr <= curAddr + 32'd4;
          end
        end else begin
          curAddr <= curAddr + 32'd4;
        end
      end
    end
  end
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int CH_INDEX   = 0,
  parameter int REQ_LINES  = 16,
  parameter int MAX_REQ_ID = 10,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [11:0]          regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 memReq,
  output logic                 memWe,
  output logic [31:0]          memAddr,
  output logic [31:0]          memWData,
  input  logic [31:0]          memRData,
  input  logic                 memReady,
  input  logic [REQ_LINES-1:0] periphReq,
  output logic [31:0]          periphTxData,
  output logic                 periphTxValid,
  input  logic [31:0]          periphRxData,
  output logic                 periphRxAck,
  output logic                 irq
);
  dmaStrobe_t       strobe;
  logic             isTx, periodEnd, burstLast, runBit, softRst;
  logic [31:0]      baseAddr;
  logic [2:0]       lastBuf;
  logic [27:0]      tcWords;
  logic [4:0]       burstWords;
  logic [CNT_W-1:0] xferCount;

  ring_dma_ctrl #(
    .CH_INDEX(CH_INDEX), .REQ_LINES(REQ_LINES),
    .MAX_REQ_ID(MAX_REQ_ID), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memReady(memReady),
    .periphReq(periphReq), .periodEnd(periodEnd), .burstLast(burstLast),
    .xferCount(xferCount), .strobe(strobe), .memReq(memReq), .isTx(isTx),
    .baseAddr(baseAddr), .lastBuf(lastBuf), .tcWords(tcWords),
    .burstWords(burstWords), .irq(irq), .runBit(runBit), .softRst(softRst)
  );

  ring_dma_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isTx(isTx), .baseAddr(baseAddr),
    .lastBuf(lastBuf), .tcWords(tcWords), .burstWords(burstWords),
    .memRData(memRData), .periphRxData(periphRxData), .memAddr(memAddr),
    .memWe(memWe), .memWData(memWData), .periphTxData(periphTxData),
    .periphTxValid(periphTxValid), .periphRxAck(periphRxAck),
    .periodEnd(periodEnd), .burstLast(burstLast), .xferCount(xferCount)
  );
endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memReady,
  input logic [31:0]      memAddr,
  input logic             irq,
  input logic             runBit,
  input logic             softRst,
  input logic             periodEnd,
  input logic [CNT_W-1:0] xferCount
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  p_addr_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  p_quiet_after_stop_r10: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (!runBit && !memReq) |=> !memReq);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN || softRst)
    periodEnd |=> (xferCount == $past(xferCount) + 1'b1));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rstN || softRst)
    periodEnd |=> irq);
endmodule

bind ring_dma_chan ring_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memReady(memReady),
  .memAddr(memAddr), .irq(irq), .runBit(runBit), .softRst(softRst),
  .periodEnd(periodEnd), .xferCount(xferCount)
);

// File: tb/tb_ring_dma_chan.sv
module tb_ring_dma_chan;
  localparam logic [31:0] TXK = 32'hC3C3_0000;
  localparam logic [31:0] RXK = 32'h5A5A_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, regWrEn, memReq, memWe, memReady, periphTxValid, periphRxAck, irq;
  logic [11:0] regAddr;
  logic [31:0] regWrData, regRdData, memAddr, memWData, memRData;
  logic [31:0] periphTxData, periphRxData;
  logic [15:0] periphReq;

  assign memRData     = memAddr ^ TXK;
  assign periphRxData = memAddr ^ RXK;

  ring_dma_chan dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData), .memReady(memReady),
    .periphReq(periphReq), .periphTxData(periphTxData), .periphTxValid(periphTxValid),
    .periphRxData(periphRxData), .periphRxAck(periphRxAck), .irq(irq)
  );

  int nTests = 0, nFail = 0, beatCnt = 0;
  bit sbOn = 0, expWe = 0, readyMode = 0, done = 0;
  logic [31:0] expQ[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitBeats(input int target, input int limit);
    int g = 0;
    while (beatCnt < target && g < limit) begin @(negedge clk); g++; end
  endtask

  // driver side of the scoreboard: expected memory addresses of a ring
  task automatic pushRing(input logic [31:0] base, input int wpp, input int nBufs, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(base + 32'(4 * (i % (wpp * nBufs))));
  endtask

  // memory ready driver
  initial begin
    memReady = 1'b1;
    forever begin
      @(posedge clk); #2;
      if (readyMode) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        memReady = lfsr[0] | lfsr[3];
      end else memReady = 1'b1;
    end
  end

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (memReq && memReady) begin
        beatCnt++;
        if (sbOn) begin
          if (expQ.size() == 0) check(1'b0, "R4 unexpected beat", memAddr, 32'h0);
          else begin
            logic [31:0] e;
            e = expQ.pop_front();
            check(memAddr == e, "R6 beat address", memAddr, e);
            if (!expWe)
              check(!memWe && periphTxValid && periphTxData == (memAddr ^ TXK),
                    "R4 read word to peripheral", periphTxData, memAddr ^ TXK);
            else
              check(memWe && periphRxAck && memWData == (memAddr ^ RXK),
                    "R5 peripheral word to memory", memWData, memAddr ^ RXK);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=%h expected=%h", beatCnt, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int b0, n;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; periphReq = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(12'h00C, rd); check(rd == 0, "R1 active after reset", rd, 0);
    regRead(12'h054, rd); check(rd == 0, "R1 counter after reset", rd, 0);
    check(!irq && !memReq, "R1 irq/memReq after reset", {irq, memReq}, 0);

    // R3 global enable gates start
    sbOn = 1; expWe = 0; readyMode = 1;
    regWrite(12'h024, 32'h0000_4200);
    regWrite(12'h028, 32'h2020_0000);
    regWrite(12'h044, 32'h0000_0010);
    regWrite(12'h034, 32'h0000_1000);
    regWrite(12'h000, 32'h1);
    repeat (10) @(negedge clk);
    check(beatCnt == 0, "R3 no beats without global enable", beatCnt, 0);
    regRead(12'h00C, rd); check(rd == 0, "R3 inactive without global enable", rd, 0);

    // R4 R6 transmit ring with stalls, three periods of four words
    pushRing(32'h1000, 4, 3, 40);
    b0 = beatCnt;
    regWrite(12'hC00, 32'h1);
    waitBeats(b0 + 24, 2000);
    regWrite(12'h000, 32'h0);
    repeat (20) @(negedge clk);
    n = beatCnt - b0;
    check(n >= 24 && n < 40, "R6 ring beats consumed", n, 24);
    regRead(12'h00C, rd); check(rd == 0, "R10 inactive after stop", rd, 0);
    check(irq == 1'b1, "R10 irq kept after stop", irq, 1);
    regRead(12'h054, rd); check(rd == 32'((n / 4) % 65536), "R9 period count", rd, (n / 4) % 65536);
    expQ.delete();

    // R8 clear while idle
    regWrite(12'h01C, 32'h1);
    check(irq == 1'b0, "R8 clear while idle", irq, 0);

    // R5 R7 receive with flow control on line 3, burst 16 cut to period of 3
    expWe = 1;
    regWrite(12'h024, 32'h0300_2202);
    regWrite(12'h028, 32'h0150_0000);
    regWrite(12'h044, 32'h0000_000C);
    regWrite(12'h03C, 32'h0000_2000);
    periphReq = 16'h0010;
    b0 = beatCnt;
    regWrite(12'h000, 32'h1);
    repeat (10) @(negedge clk);
    check(beatCnt == b0, "R7 wrong request line gives no burst", beatCnt - b0, 0);
    regRead(12'h00C, rd); check(rd == 1, "R7 active while waiting", rd, 1);
    pushRing(32'h2000, 3, 2, 16);
    periphReq = 16'h0008;
    waitBeats(b0 + 12, 2000);
    regWrite(12'h000, 32'h0);
    repeat (20) @(negedge clk);
    n = beatCnt - b0;
    check(n >= 12 && n < 16, "R5 receive beats", n, 12);
    regRead(12'h054, rd); check(rd == 32'(n / 3), "R9 receive period count", rd, n / 3);
    expQ.delete();
    periphReq = '0;

    // R7 burst length 2 with one-cycle request pulses, period of 3 words
    expWe = 0; readyMode = 0;
    regWrite(12'h024, 32'h1000_4202);
    regWrite(12'h028, 32'h0020_0000);
    regWrite(12'h044, 32'h0000_000C);
    regWrite(12'h034, 32'h0000_3000);
    expQ.push_back(32'h3000); expQ.push_back(32'h3004); expQ.push_back(32'h3008);
    expQ.push_back(32'h3000); expQ.push_back(32'h3004);
    regWrite(12'h000, 32'h1);
    repeat (5) @(negedge clk);
    b0 = beatCnt;
    @(negedge clk); periphReq = 16'h0002; @(negedge clk); periphReq = '0;
    repeat (10) @(negedge clk);
    check(beatCnt - b0 == 2, "R7 burst of two words", beatCnt - b0, 2);
    b0 = beatCnt;
    @(negedge clk); periphReq = 16'h0002; @(negedge clk); periphReq = '0;
    repeat (10) @(negedge clk);
    check(beatCnt - b0 == 1, "R7 burst cut at period end", beatCnt - b0, 1);
    b0 = beatCnt;
    @(negedge clk); periphReq = 16'h0002; @(negedge clk); periphReq = '0;
    repeat (10) @(negedge clk);
    check(beatCnt - b0 == 2, "R7 burst after wrap", beatCnt - b0, 2);
    regWrite(12'h000, 32'h0);
    repeat (5) @(negedge clk);
    expQ.delete();

    // R8 set/clear collision and R9 counter wrap: one-word periods, every cycle
    sbOn = 0;
    regWrite(12'h024, 32'h0000_4200);
    regWrite(12'h028, 32'h0010_0000);
    regWrite(12'h044, 32'h0000_0004);
    regWrite(12'h034, 32'h0000_4000);
    b0 = beatCnt;
    regWrite(12'h000, 32'h1);
    repeat (20) @(negedge clk);
    regWrite(12'h01C, 32'h1);
    check(irq == 1'b1, "R8 period end beats clear", irq, 1);
    repeat (7) @(negedge clk);
    regWrite(12'h01C, 32'h1);
    check(irq == 1'b1, "R8 period end beats clear again", irq, 1);
    waitBeats(b0 + 65538, 70000);
    regWrite(12'h000, 32'h0);
    repeat (10) @(negedge clk);
    n = beatCnt - b0;
    regRead(12'h054, rd);
    check(rd == 32'(n % 65536), "R9 counter wraps", rd, n % 65536);

    // R2 soft reset while running
    regWrite(12'h000, 32'h1);
    repeat (10) @(negedge clk);
    regWrite(12'hC04, 32'h1);
    regRead(12'hC04, rd); check(rd == 0, "R2 soft reset self clears", rd, 0);
    regRead(12'h00C, rd); check(rd == 0, "R2 idle after soft reset", rd, 0);
    regRead(12'h024, rd); check(rd == 0, "R2 control cleared", rd, 0);
    regRead(12'hC00, rd); check(rd == 0, "R2 global enable cleared", rd, 0);
    regRead(12'h054, rd); check(rd == 0, "R2 counter cleared", rd, 0);
    check(irq == 1'b0, "R2 irq cleared", irq, 0);
    b0 = beatCnt;
    repeat (10) @(negedge clk);
    check(beatCnt == b0 && !memReq, "R2 no beats after soft reset", beatCnt - b0, 0);

    // R12 invalid direction and mode
    regWrite(12'hC00, 32'h1);
    regWrite(12'h024, 32'h0000_3200);
    regWrite(12'h000, 32'h1);
    repeat (10) @(negedge clk);
    regRead(12'h00C, rd); check(rd == 0, "R12 direction 3 stays idle", rd, 0);
    regWrite(12'h024, 32'h0000_4100);
    repeat (10) @(negedge clk);
    regRead(12'h00C, rd); check(rd == 0, "R12 mode 1 stays idle", rd, 0);
    check(beatCnt == b0, "R12 no beats", beatCnt - b0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule